// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block keeps the interrupt state of a simple Ethernet MAC. Three transmit sources feed it: bus error, descriptor unavailable and frame sent. Three receive sources feed it: bus error, descriptor unavailable and good frame. Each source arrives as a single-cycle pulse and sets a sticky pending bit. Software clears a pending bit by writing 1 to it.

Each direction has its own enable register field. A per-direction summary bit is set whenever a pending source is also enabled. The summary bit appears inside the status word. Each direction drives one level-sensitive interrupt line, which is high when its summary bit is set and the enable bit at the summary position is also set.

Software reaches the block through a 32-bit register port with a one-cycle read latency. A soft reset input and the asynchronous reset both clear all state.

Top module: `mac_irq_agg`

## Requirements
- R1: After reset, the enable word, the status word, the read data and both interrupt lines are all zero.
- R2: Event bits are positioned as follows. The transmit half is the upper 16 bits: 16 is the transmit summary, 17 is frame sent (tx_evt_i[0]), 18 is bus error (tx_evt_i[1]) and 19 is descriptor unavailable (tx_evt_i[2]). The receive half uses the same layout from bit 0: 0 is the receive summary, 1 is good frame, 2 is bus error and 3 is descriptor unavailable. A pulse sets its bit, and the bit stays set until it is cleared.
- R3: A write to the status address (1) clears every pending bit whose data bit is 1 and leaves pending bits under 0 unchanged.
- R4: An event pulse in the same cycle as a clear of its bit wins, so the bit remains set.
- R5: Bit 16 reads 1 exactly when at least one of bits 17..19 is both pending and enabled. The enable bits share the status bit positions.
- R6: Bit 0 reads 1 exactly when at least one of bits 1..3 is both pending and enabled.
- R7: tx_irq_o is high only when status bit 16 and enable bit 16 are both 1. rx_irq_o follows the same rule with bit 0.
- R8: Writing 1 to a summary position of the status word has no effect; summaries follow only pending and enabled sources.
- R9: A read strobe returns, on the next cycle, the enable word for address 0, the status word for address 1, and zero for any other address. Writes to other addresses change nothing.
- R10: A soft reset clears the status and enable words and drops both interrupt lines by the next cycle. It overrides any event arriving in the same cycle.
- R11: Only bits 0..3 and 16..19 of either word store state; all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous clear of all state |
| tx_evt_i | input | 3 | Transmit event pulses: sent, bus error, descriptor unavailable |
| rx_evt_i | input | 3 | Receive event pulses: good, bus error, descriptor unavailable |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 status |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| tx_irq_o | output | 1 | Transmit interrupt level |
| rx_irq_o | output | 1 | Receive interrupt level |

## Verification
On every cycle, the assertions check that each interrupt line is backed by a set summary bit and its enable. They check that a summary bit is backed by an enabled pending source, and that an event pulse beats a simultaneous clear. They also check that a pending bit only falls after a clear or a soft reset, that a soft reset empties both words, and that status reads return the previous cycle's word. The bench scenarios are what show the exact bit positions and the masking of undefined bits. They also show that summary writes are ignored, that an address outside the map has no effect, and that removing an enable drops an interrupt while the source stays pending.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  // layout inside each 16-bit half: summary at 0, sources from 1 up
  localparam int unsigned SUM_POS  = 0;
  localparam int unsigned SRC_BASE = 1;

  localparam int unsigned ADDR_ENABLE = 0;
  localparam int unsigned ADDR_STATUS = 1;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } irq_dir_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         soft_rst_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= '0;
    else if (soft_rst_i) pend_q <= '0;
    else                 pend_q <= (pend_q & ~clr_mask) | set_i; // set wins
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_dir_slice.sv
module irq_dir_slice
  import mac_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  localparam int unsigned FW     = NUM_SRC + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               en_we_i,
  input  logic               st_we_i,
  input  logic [FW-1:0]      wdata_i,
  output logic [FW-1:0]      stat_o,
  output logic [FW-1:0]      en_o,
  output logic               irq_o
);
  logic [FW-1:0]      en_q;
  logic [NUM_SRC-1:0] pend;
  logic               sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= '0;
    else if (soft_rst_i) en_q <= '0;
    else if (en_we_i)    en_q <= wdata_i;
  end

  irq_pend_reg #(.N(NUM_SRC)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .set_i      (evt_i),
    .clr_we_i   (st_we_i),
    .clr_i      (wdata_i[SRC_BASE +: NUM_SRC]),
    .pend_o     (pend)
  );

  // summary bit is never stored; software writes to it are lost
  assign sum = |(pend & en_q[SRC_BASE +: NUM_SRC]);

  assign stat_o[SUM_POS]             = sum;
  assign stat_o[SRC_BASE +: NUM_SRC] = pend;
  assign en_o                        = en_q;
  assign irq_o                       = sum & en_q[SUM_POS];
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import mac_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] en_word_i,
  input  logic [DATA_W-1:0] stat_word_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rsel;

  always_comb begin
    rsel = '0;
    if (addr_i == ADDR_W'(ADDR_ENABLE))      rsel = en_word_i;
    else if (addr_i == ADDR_W'(ADDR_STATUS)) rsel = stat_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_q <= '0;
    else if (soft_rst_i) rdata_q <= '0;
    else if (re_i)       rdata_q <= rsel;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
  import mac_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned NUM_SRC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic [NUM_SRC-1:0] tx_evt_i,
  input  logic [NUM_SRC-1:0] rx_evt_i,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               tx_irq_o,
  output logic               rx_irq_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned FW     = NUM_SRC + 1;
  localparam int unsigned PAD_W  = HALF_W - FW;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] en_word;
  logic [1:0]        irq_vec;
  logic              en_we;
  logic              st_we;
  logic              unused_wdata;

  assign en_we        = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_ENABLE));
  assign st_we        = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_STATUS));
  assign unused_wdata = ^reg_wdata_i;

  for (genvar d = 0; d < 2; d++) begin : g_dir
    localparam int unsigned BASE = d * HALF_W;
    logic [NUM_SRC-1:0] evt;
    logic [FW-1:0]      stat_f;
    logic [FW-1:0]      en_f;

    if (d == int'(DIR_TX)) begin : g_tx
      assign evt = tx_evt_i;
    end else begin : g_rx
      assign evt = rx_evt_i;
    end

    irq_dir_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .soft_rst_i (soft_rst_i),
      .evt_i      (evt),
      .en_we_i    (en_we),
      .st_we_i    (st_we),
      .wdata_i    (reg_wdata_i[BASE +: FW]),
      .stat_o     (stat_f),
      .en_o       (en_f),
      .irq_o      (irq_vec[d])
    );

    assign stat_word[BASE +: FW]       = stat_f;
    assign en_word[BASE +: FW]         = en_f;
    assign stat_word[BASE + FW +: PAD_W] = '0;
    assign en_word[BASE + FW +: PAD_W]   = '0;
  end

  irq_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst_i),
    .re_i        (reg_re_i),
    .addr_i      (reg_addr_i),
    .en_word_i   (en_word),
    .stat_word_i (stat_word),
    .rdata_o     (reg_rdata_o)
  );

  assign tx_irq_o = irq_vec[int'(DIR_TX)];
  assign rx_irq_o = irq_vec[int'(DIR_RX)];
endmodule

// File: rtl/mac_irq_agg_chk.sv
module mac_irq_agg_chk
  import mac_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned NUM_SRC = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               soft_rst_i,
  input logic [NUM_SRC-1:0] tx_evt_i,
  input logic               reg_we_i,
  input logic               reg_re_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i,
  input logic [DATA_W-1:0]  reg_rdata_o,
  input logic               tx_irq_o,
  input logic               rx_irq_o,
  input logic [DATA_W-1:0]  stat_word,
  input logic [DATA_W-1:0]  en_word
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned TX_SUM = HALF_W;
  localparam int unsigned TX_DONE = HALF_W + 1;

  a_r4_evt_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_i && tx_evt_i[0]) |=> stat_word[TX_DONE]);

  a_r3_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_word[TX_DONE] && !soft_rst_i &&
     !(reg_we_i && reg_addr_i == ADDR_W'(ADDR_STATUS) && reg_wdata_i[TX_DONE]))
    |=> stat_word[TX_DONE]);

  a_r10_soft_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (stat_word == '0 && en_word == '0 && !tx_irq_o && !rx_irq_o));

  a_r7_tx_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> (en_word[TX_SUM] && stat_word[TX_SUM]));

  a_r7_rx_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (en_word[0] && stat_word[0]));

  a_r5_tx_sum_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word[TX_SUM] |-> |(stat_word[TX_SUM+1 +: NUM_SRC] & en_word[TX_SUM+1 +: NUM_SRC]));

  a_r6_rx_sum_backed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_word[0] |-> |(stat_word[1 +: NUM_SRC] & en_word[1 +: NUM_SRC]));

  a_r9_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !soft_rst_i && reg_addr_i == ADDR_W'(ADDR_STATUS))
    |=> reg_rdata_o == $past(stat_word));
endmodule

bind mac_irq_agg mac_irq_agg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .tx_evt_i    (tx_evt_i),
  .reg_we_i    (reg_we_i),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .tx_irq_o    (tx_irq_o),
  .rx_irq_o    (rx_irq_o),
  .stat_word   (stat_word),
  .en_word     (en_word)
);

// File: tb/mac_irq_agg_test.sv
module mac_irq_agg_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [2:0]  tx_evt = '0;
  logic [2:0]  rx_evt = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_irq, rx_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit rd_pend = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_agg uut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
  );

  always @(posedge clk) rd_pend <= rst_n && re;

  // monitor: compare read data one cycle after each strobe
  always @(negedge clk) begin
    if (rd_pend) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected read data act=%h exp=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s rdata act=%h exp=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic [2:0] tx, input logic [2:0] rx, input logic sr);
    @(negedge clk);
    we = w; addr = a; wdata = d; tx_evt = tx; rx_evt = rx; soft_rst = sr;
    @(negedge clk);
    we = 1'b0; wdata = '0; tx_evt = '0; rx_evt = '0; soft_rst = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    re = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_irq(input logic etx, input logic erx, input string t);
    n_chk++;
    if (tx_irq !== etx || rx_irq !== erx) begin
      n_fail++;
      $display("FAIL %s irq act=%b%b exp=%b%b", t, tx_irq, rx_irq, etx, erx);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(0, 0, "R1");
    rd(2'd0, 32'h0, "R1 enable");
    rd(2'd1, 32'h0, "R1 status");
    // R2 sent event sticks, no irq without enable
    cyc(0, 2'd0, 0, 3'b001, 3'b000, 0);
    cyc(0, 2'd0, 0, 3'b000, 3'b000, 0);
    rd(2'd1, 32'h0002_0000, "R2 sent bit17");
    chk_irq(0, 0, "R7 no enable");
    // R5/R7 enable source and summary
    cyc(1, 2'd0, 32'h0003_0000, 3'b000, 3'b000, 0);
    chk_irq(1, 0, "R7 tx irq");
    rd(2'd1, 32'h0003_0000, "R5 tx summary");
    rd(2'd0, 32'h0003_0000, "R9 enable read");
    // R7 summary enable off: summary stays, line drops
    cyc(1, 2'd0, 32'h0002_0000, 3'b000, 3'b000, 0);
    chk_irq(0, 0, "R7 summary enable off");
    rd(2'd1, 32'h0003_0000, "R5 summary independent of line");
    cyc(1, 2'd0, 32'h0003_0000, 3'b000, 3'b000, 0);
    // R3 writing zeros keeps, ones clear
    cyc(1, 2'd1, 32'h0, 3'b000, 3'b000, 0);
    rd(2'd1, 32'h0003_0000, "R3 zero write");
    cyc(1, 2'd1, 32'h0002_0000, 3'b000, 3'b000, 0);
    chk_irq(0, 0, "R3 cleared");
    rd(2'd1, 32'h0, "R3 w1c");
    // R8 summary not writable
    cyc(1, 2'd1, 32'h0001_0001, 3'b000, 3'b000, 0);
    rd(2'd1, 32'h0, "R8 summary write");
    chk_irq(0, 0, "R8 irq");
    // R11 undefined bits
    cyc(1, 2'd0, 32'hFFFF_FFFF, 3'b000, 3'b000, 0);
    rd(2'd0, 32'h000F_000F, "R11 enable mask");
    // R6 rx descriptor unavailable
    cyc(0, 2'd0, 0, 3'b000, 3'b100, 0);
    chk_irq(0, 1, "R6 rx irq");
    rd(2'd1, 32'h0000_0009, "R6 rx summary");
    // R4 event wins over clear
    cyc(1, 2'd1, 32'h0000_0008, 3'b000, 3'b100, 0);
    rd(2'd1, 32'h0000_0009, "R4 set beats clear");
    cyc(1, 2'd1, 32'h0000_0008, 3'b000, 3'b000, 0);
    chk_irq(0, 0, "R3 rx cleared");
    // multiple sources both directions
    cyc(0, 2'd0, 0, 3'b110, 3'b011, 0);
    chk_irq(1, 1, "R7 both lines");
    rd(2'd1, 32'h000D_0007, "R2 multi sources");
    cyc(1, 2'd1, 32'h0004_0002, 3'b000, 3'b000, 0);
    rd(2'd1, 32'h0009_0005, "R3 partial clear");
    chk_irq(1, 1, "R3 partial irq");
    cyc(1, 2'd0, 32'h0001_0001, 3'b000, 3'b000, 0);
    chk_irq(0, 0, "R5 sources disabled");
    rd(2'd1, 32'h0008_0004, "R6 pending kept summary off");
    // R10 soft reset beats events
    cyc(0, 2'd0, 0, 3'b001, 3'b001, 1);
    chk_irq(0, 0, "R10 irq low");
    rd(2'd1, 32'h0, "R10 status");
    rd(2'd0, 32'h0, "R10 enable");
    // R9 unmapped addresses
    cyc(1, 2'd3, 32'hFFFF_FFFF, 3'b000, 3'b000, 0);
    rd(2'd0, 32'h0, "R9 unmapped write ignored");
    cyc(0, 2'd0, 0, 3'b010, 3'b000, 0);
    rd(2'd2, 32'h0, "R9 unmapped read zero");
    rd(2'd1, 32'h0004_0000, "R9 status after unmapped");
    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 reads outstanding act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule